// File: doc/BRIEF.md
# Single-Entry Loop Branch Predictor

This block is a one-entry branch target buffer for a short in-order pipeline. It remembers the address of one conditional branch and where that branch went. When the fetch stage presents that same address again, the block raises a hit flag and supplies the remembered destination in the same cycle. Fetch can then jump straight there, without waiting for the execute stage to resolve the branch, so a correctly predicted taken branch costs no fetch bubble.

The execute stage reports each resolved control-flow instruction: its address and target, whether it was a conditional branch, whether it was taken, whether it jumped backward, and whether fetch had predicted it. Only a taken backward conditional branch, the closing branch of a loop, fills or replaces the entry. The entry is dropped when a predicted branch turns out not taken, on an instruction-cache synchronisation fence, and on any trap. Branch resolution and the fetch queue are outside this block.

Top module: `loop_btb`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, the entry is empty and `pred_hit` is 0 for every fetch address.
- R2: A report with `res_valid`, `res_cond`, `res_taken` and `res_backward` all 1 stores `res_pc` and `res_target`; from the next cycle, `fetch_pc` equal to the stored address gives `pred_hit` = 1 and `pred_target` = stored target.
- R3: `pred_hit` is combinational on `fetch_pc`: it is 1 only when the entry is valid and `fetch_pc` equals the stored address exactly, and `pred_target` is 0 whenever `pred_hit` is 0.
- R4: Forward taken branches (`res_backward` = 0), jumps (`res_cond` = 0) and not-taken branches that were not predicted neither fill nor change the entry.
- R5: A report with `res_valid` = 1, `res_predicted` = 1 and `res_taken` = 0 empties the entry from the next cycle.
- R6: `fencei` = 1 empties the entry from the next cycle.
- R7: `trap` = 1 empties the entry from the next cycle.
- R8: When a fill and an emptying event occur in the same cycle, the entry ends empty.
- R9: A new fill replaces an existing entry; the old address no longer hits.
- R10: With `res_valid` = 0 all other resolution inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address being fetched |
| pred_hit | output | 1 | Stored branch address matches `fetch_pc` |
| pred_target | output | ADDR_W | Predicted destination, 0 when no hit |
| res_valid | input | 1 | A resolved control-flow instruction is reported |
| res_cond | input | 1 | It is a conditional branch (0: jump) |
| res_taken | input | 1 | It was taken |
| res_backward | input | 1 | Its target is below its own address |
| res_predicted | input | 1 | Fetch predicted it taken |
| res_pc | input | ADDR_W | Its address |
| res_target | input | ADDR_W | Its destination |
| fencei | input | 1 | Instruction fence executed |
| trap | input | 1 | Trap taken |

## Verification
A fill from a taken backward branch and an emptying event can land in one cycle. The bench drives a fill together with a trap, and a fill together with a fence, in the same clock, then probes the would-be address on the following cycle and requires a miss. The checker also holds that every emptying cycle is followed by an empty entry regardless of a concurrent fill.

// File: rtl/loop_btb.sv
module loop_btb #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              res_valid,
  input  logic              res_cond,
  input  logic              res_taken,
  input  logic              res_backward,
  input  logic              res_predicted,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              fencei,
  input  logic              trap
);

  logic              ent_valid;
  logic [ADDR_W-1:0] ent_src;
  logic [ADDR_W-1:0] ent_tgt;

  wire fill  = res_valid & res_cond & res_taken & res_backward;
  wire clear = fencei | trap | (res_valid & res_predicted & ~res_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= 1'b0;
      ent_src   <= '0;
      ent_tgt   <= '0;
    end else if (clear) begin
      ent_valid <= 1'b0;
    end else if (fill) begin
      ent_valid <= 1'b1;
      ent_src   <= res_pc;
      ent_tgt   <= res_target;
    end
  end

  assign pred_hit    = ent_valid && (fetch_pc == ent_src);
  assign pred_target = pred_hit ? ent_tgt : '0;

endmodule

// File: rtl/loop_btb_chk.sv
module loop_btb_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pred_hit,
  input logic [ADDR_W-1:0] pred_target,
  input logic              res_valid,
  input logic              res_cond,
  input logic              res_taken,
  input logic              res_backward,
  input logic              res_predicted,
  input logic [ADDR_W-1:0] res_pc,
  input logic [ADDR_W-1:0] res_target,
  input logic              fencei,
  input logic              trap,
  input logic              ent_valid,
  input logic [ADDR_W-1:0] ent_src,
  input logic [ADDR_W-1:0] ent_tgt
);

  logic ev_fill, ev_clear;
  assign ev_fill  = res_valid && res_cond && res_taken && res_backward;
  assign ev_clear = fencei || trap || (res_valid && res_predicted && !res_taken);

  a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> !ent_valid);

  a_r2_fill_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill && !ev_clear) |=> (ent_valid && ent_src == $past(res_pc) && ent_tgt == $past(res_target)));

  a_r3_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_valid |-> !pred_hit);

  a_r3_miss_zero_target: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> pred_target == '0);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_fill && !ev_clear) |=> ($stable(ent_valid) && $stable(ent_src) && $stable(ent_tgt)));

  a_r5_mispredict_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_predicted && !res_taken) |=> !ent_valid);

  a_r6_fence_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fencei |=> !ent_valid);

  a_r7_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !ent_valid);

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill && ev_clear) |=> !ent_valid);

endmodule

bind loop_btb loop_btb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_hit(pred_hit), .pred_target(pred_target),
  .res_valid(res_valid), .res_cond(res_cond), .res_taken(res_taken),
  .res_backward(res_backward), .res_predicted(res_predicted),
  .res_pc(res_pc), .res_target(res_target), .fencei(fencei), .trap(trap),
  .ent_valid(ent_valid), .ent_src(ent_src), .ent_tgt(ent_tgt)
);

// File: tb/loop_btb_test.sv
module loop_btb_test;
  localparam int ADDR_W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] fetch_pc = '0;
  logic pred_hit;
  logic [ADDR_W-1:0] pred_target;
  logic res_valid = 0, res_cond = 0, res_taken = 0, res_backward = 0, res_predicted = 0;
  logic [ADDR_W-1:0] res_pc = '0, res_target = '0;
  logic fencei = 0, trap = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_btb #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_target(pred_target),
    .res_valid(res_valid), .res_cond(res_cond), .res_taken(res_taken),
    .res_backward(res_backward), .res_predicted(res_predicted),
    .res_pc(res_pc), .res_target(res_target), .fencei(fencei), .trap(trap)
  );

  // flags {fencei,trap,valid,cond,taken,backward,predicted}, pc, target, probe, hit, expected target
  localparam logic [71:0] VEC [NV] = '{
    {7'b0011110, 16'h0100, 16'h00C0, 16'h0100, 1'b1, 16'h00C0}, // R2 fill
    {7'b0001110, 16'h0200, 16'h0010, 16'h0200, 1'b0, 16'h0000}, // R10 invalid report
    {7'b0000000, 16'h0000, 16'h0000, 16'h0100, 1'b1, 16'h00C0}, // R2 persists
    {7'b0011100, 16'h0300, 16'h0400, 16'h0300, 1'b0, 16'h0000}, // R4 forward taken
    {7'b0010110, 16'h0500, 16'h0080, 16'h0500, 1'b0, 16'h0000}, // R4 jump
    {7'b0000000, 16'h0000, 16'h0000, 16'h0100, 1'b1, 16'h00C0}, // R4 entry kept
    {7'b0011010, 16'h0100, 16'h00C0, 16'h0100, 1'b1, 16'h00C0}, // R4 unpredicted not-taken
    {7'b0011011, 16'h0100, 16'h00C0, 16'h0100, 1'b0, 16'h0000}, // R5 mispredict
    {7'b0011110, 16'h0200, 16'h01F0, 16'h0200, 1'b1, 16'h01F0}, // R2 refill
    {7'b0011110, 16'h0280, 16'h0210, 16'h0200, 1'b0, 16'h0000}, // R9 old address gone
    {7'b0000000, 16'h0000, 16'h0000, 16'h0280, 1'b1, 16'h0210}, // R9 new address hits
    {7'b1000000, 16'h0000, 16'h0000, 16'h0280, 1'b0, 16'h0000}, // R6 fence
    {7'b0011110, 16'h0300, 16'h0100, 16'h0300, 1'b1, 16'h0100}, // R2 fill
    {7'b0100000, 16'h0000, 16'h0000, 16'h0300, 1'b0, 16'h0000}, // R7 trap
    {7'b0111110, 16'h0400, 16'h0300, 16'h0400, 1'b0, 16'h0000}, // R8 fill with trap
    {7'b1011110, 16'h0400, 16'h0300, 16'h0400, 1'b0, 16'h0000}  // R8 fill with fence
  };

  task automatic check(input string req, input logic exp_hit, input logic [ADDR_W-1:0] exp_tgt);
    checks++;
    if (pred_hit !== exp_hit || pred_target !== exp_tgt) begin
      errors++;
      $display("FAIL %s hit=%0b target=%h expected hit=%0b target=%h", req, pred_hit, pred_target, exp_hit, exp_tgt);
    end
  endtask

  task automatic idle_res();
    {fencei, trap, res_valid, res_cond, res_taken, res_backward, res_predicted} = '0;
    res_pc = '0; res_target = '0;
  endtask

  task automatic fill(input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] tgt);
    @(negedge clk);
    {res_valid, res_cond, res_taken, res_backward} = 4'b1111;
    res_pc = pc; res_target = tgt;
    @(negedge clk);
    idle_res();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    fetch_pc = 32'h0000_0000;
    #1 check("R1 in reset", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R1 after reset", 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {fencei, trap, res_valid, res_cond, res_taken, res_backward, res_predicted} = VEC[i][71:65];
      res_pc = {16'h0, VEC[i][64:49]};
      res_target = {16'h0, VEC[i][48:33]};
      @(negedge clk);
      idle_res();
      fetch_pc = {16'h0, VEC[i][32:17]};
      #1 check($sformatf("vector %0d", i), VEC[i][16], {16'h0, VEC[i][15:0]});
    end

    fill(32'h8000_1000, 32'h8000_0F00);
    fetch_pc = 32'h8000_1000;
    #1 check("R3 exact match", 1'b1, 32'h8000_0F00);
    fetch_pc = 32'h8000_1004;
    #1 check("R3 neighbour address", 1'b0, '0);
    fetch_pc = 32'h0000_1000;
    #1 check("R3 upper bits differ", 1'b0, '0);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    fetch_pc = 32'h8000_1000;
    #1 check("R1 reset drops entry", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R1 empty after release", 1'b0, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule